// File: doc/BRIEF.md
# Host Buffer Access Port

This block puts a packet buffer memory behind a small register window on a host CPU bus. The host fills outgoing packets by writing again and again to one data-port address. Each write lands at the transmit pointer, which then steps forward. The host drains received packets by reading from the same data-port address. Each read returns the byte or word at the receive pointer, which then steps forward. Both pointers sit behind that one address, so a packet moves with no address arithmetic on the host side.

The port runs in byte mode or in 16-bit word mode, chosen by a bit in the control register. In word mode the data port and the companion high-byte lane must always be accessed together as one 16-bit transfer. A half-width access to the data port in that mode is dropped, and a sticky error flag records it. The control register and both pointer registers always accept full-word, low-lane-only or high-lane-only access. The buffer side is a 16-bit synchronous RAM with byte write enables, addressed by word. Read data reaches the host one cycle after the read strobe.

Host register map (word index on `hostAddr`). Index 0 is the data port: lane 0 is the data byte or the low byte, and lane 1 is the companion high byte, used only in word mode. Index 1 is control: bit 0 selects word mode when 1, and bit 1 is the sticky error flag, cleared by writing 1 to it. Index 2 is the transmit pointer. Index 3 is the receive pointer. Both pointers are byte addresses, zero-extended on reads.

Top module: `hostBufPort`

## Requirements
- R1: In byte mode, a write to index 0 with lane 0 enabled stores hostWdata[7:0] at byte address txPtr, which is RAM word txPtr>>1, high lane when txPtr bit 0 is 1. txPtr then advances by 1. Lane 1 data is ignored.
- R2: In byte mode, a read of index 0 with lane 0 enabled returns the byte at rxPtr on hostRdata[7:0], with bits 15..8 zero, in the cycle after the strobe. rxPtr then advances by 1.
- R3: In word mode, a write to index 0 with both lanes enabled stores hostWdata at RAM word txPtr>>1, with the low byte at the even address. txPtr then advances by 2.
- R4: In word mode, a read of index 0 with both lanes enabled returns the 16-bit RAM word at rxPtr>>1 in the cycle after the strobe. rxPtr then advances by 2.
- R5: In word mode, an access to index 0 with exactly one lane enabled causes no RAM access and moves no pointer, and a read returns 0. It sets control bit 1, which stays set until written with 1 through lane 0 of index 1.
- R6: In byte mode, an access to index 0 with only lane 1 enabled does nothing: no RAM access, no pointer change and no error.
- R7: After reset both pointers are 0, byte mode is selected and the error flag is clear. Writes to index 2 and index 3 load the transmit and receive pointers, and reads of those indices return them.
- R8: Register lanes are independent. Lane 0 of a pointer register writes its bits 7..0, and lane 1 writes the remaining upper bits, leaving the other lane unchanged.
- R9: Pointers wrap modulo 2^PTR_W: a byte-mode access at the last address returns the pointer to 0.
- R10: Register reads return in the cycle after the strobe, and hostRdata is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 2 | Register word index |
| hostBe | input | 2 | Byte lane enables (bit 0 low lane, bit 1 high lane) |
| hostWr | input | 1 | Write strobe, one cycle per access |
| hostRd | input | 1 | Read strobe, one cycle per access |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data, valid the cycle after hostRd |
| ramAddr | output | PTR_W-1 | RAM word address |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read enable |
| ramBe | output | 2 | RAM byte-lane write enables |
| ramWdata | output | 16 | RAM write data |
| ramRdata | input | 16 | RAM read data, one cycle after ramRe |

## Verification
In byte mode the data port is driven with low-lane-only, both-lane and high-lane-only enables. This shows the true byte transfer apart from the ignored upper lane and from the no-op case. In word mode it is driven with both-lane and single-lane enables, which shows full word transfers apart from rejected partial ones and shows that the error flag is sticky until cleared. Pointer loads through one lane at a time show lane independence. Accesses at the top address show wrap-around, and a byte read of a word-written location shows the lane routing to and from the RAM.

// File: rtl/hbpPkg.sv
package hbpPkg;
  localparam logic [1:0] REG_PORT = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_TXP  = 2'd2;
  localparam logic [1:0] REG_RXP  = 2'd3;

  typedef struct packed {
    logic       portWr;
    logic       portRd;
    logic       partialErr;
    logic       ctlWrLo;
    logic       txLdLo;
    logic       txLdHi;
    logic       rxLdLo;
    logic       rxLdHi;
    logic       regRd;
    logic [1:0] regSel;
  } hbpStrobes_t;

  typedef enum logic [2:0] {
    TAG_NONE,
    TAG_LO,
    TAG_HI,
    TAG_WORD,
    TAG_REG
  } rdTag_t;
endpackage

// File: rtl/hbpCtrl.sv
module hbpCtrl
  import hbpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic [1:0]  hostBe,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic        wordMode,
  output hbpStrobes_t stb
);
  logic wrEff, rdEff, isPort, portOk, partial;

  always_comb begin
    wrEff   = hostWr;
    rdEff   = hostRd && !hostWr;
    isPort  = (hostAddr == REG_PORT);
    portOk  = wordMode ? (hostBe == 2'b11) : hostBe[0];
    partial = wordMode && (hostBe[0] ^ hostBe[1]);

    stb            = '0;
    stb.portWr     = wrEff && isPort && portOk;
    stb.portRd     = rdEff && isPort && portOk;
    stb.partialErr = (wrEff || rdEff) && isPort && partial;
    stb.ctlWrLo    = wrEff && (hostAddr == REG_CTL) && hostBe[0];
    stb.txLdLo     = wrEff && (hostAddr == REG_TXP) && hostBe[0];
    stb.txLdHi     = wrEff && (hostAddr == REG_TXP) && hostBe[1];
    stb.rxLdLo     = wrEff && (hostAddr == REG_RXP) && hostBe[0];
    stb.rxLdHi     = wrEff && (hostAddr == REG_RXP) && hostBe[1];
    stb.regRd      = rdEff && !isPort;
    stb.regSel     = hostAddr;
  end

  // R5: a half-width data-port access in word mode never becomes a transfer
  a_r5_partial_no_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == REG_PORT && wordMode && hostBe != 2'b11 && (hostWr || hostRd))
      |-> (!stb.portWr && !stb.portRd));

  // R6: high-lane-only data-port access in byte mode is a pure no-op
  a_r6_hi_lane_noop: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == REG_PORT && !wordMode && hostBe == 2'b10)
      |-> (!stb.portWr && !stb.portRd && !stb.partialErr));
endmodule

// File: rtl/hbpDatapath.sv
module hbpDatapath
  import hbpPkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  hbpStrobes_t        stb,
  input  logic [15:0]        hostWdata,
  output logic [15:0]        hostRdata,
  output logic               wordMode,
  output logic [PTR_W-2:0]   ramAddr,
  output logic               ramWe,
  output logic               ramRe,
  output logic [1:0]         ramBe,
  output logic [15:0]        ramWdata,
  input  logic [15:0]        ramRdata
);
  localparam int HI_W  = PTR_W - 8;
  localparam int PAD_W = 16 - PTR_W;

  logic [PTR_W-1:0] txPtr, rxPtr, step;
  logic             errQ;
  rdTag_t           rdTag;
  logic [15:0]      rdReg, regMux;

  assign wordMode = wordModeQ;
  logic wordModeQ;

  always_comb step = wordModeQ ? PTR_W'(2) : PTR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPtr     <= '0;
      rxPtr     <= '0;
      wordModeQ <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (stb.portWr) txPtr <= txPtr + step;
      else begin
        if (stb.txLdLo) txPtr[7:0]       <= hostWdata[7:0];
        if (stb.txLdHi) txPtr[PTR_W-1:8] <= hostWdata[8 +: HI_W];
      end
      if (stb.portRd) rxPtr <= rxPtr + step;
      else begin
        if (stb.rxLdLo) rxPtr[7:0]       <= hostWdata[7:0];
        if (stb.rxLdHi) rxPtr[PTR_W-1:8] <= hostWdata[8 +: HI_W];
      end
      if (stb.ctlWrLo) wordModeQ <= hostWdata[0];
      if (stb.partialErr) errQ <= 1'b1;
      else if (stb.ctlWrLo && hostWdata[1]) errQ <= 1'b0;
    end
  end

  always_comb begin
    case (stb.regSel)
      REG_CTL: regMux = {14'd0, errQ, wordModeQ};
      REG_TXP: regMux = {{PAD_W{1'b0}}, txPtr};
      REG_RXP: regMux = {{PAD_W{1'b0}}, rxPtr};
      default: regMux = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdTag <= TAG_NONE;
      rdReg <= '0;
    end else begin
      rdTag <= TAG_NONE;
      if (stb.portRd) begin
        if (wordModeQ)     rdTag <= TAG_WORD;
        else if (rxPtr[0]) rdTag <= TAG_HI;
        else               rdTag <= TAG_LO;
      end else if (stb.regRd) begin
        rdTag <= TAG_REG;
        rdReg <= regMux;
      end
    end
  end

  always_comb begin
    case (rdTag)
      TAG_LO:   hostRdata = {8'd0, ramRdata[7:0]};
      TAG_HI:   hostRdata = {8'd0, ramRdata[15:8]};
      TAG_WORD: hostRdata = ramRdata;
      TAG_REG:  hostRdata = rdReg;
      default:  hostRdata = 16'd0;
    endcase
  end

  always_comb begin
    ramWe    = stb.portWr;
    ramRe    = stb.portRd;
    ramAddr  = stb.portWr ? txPtr[PTR_W-1:1] : rxPtr[PTR_W-1:1];
    ramWdata = wordModeQ ? hostWdata : {hostWdata[7:0], hostWdata[7:0]};
    if (!stb.portWr)   ramBe = 2'b00;
    else if (wordModeQ) ramBe = 2'b11;
    else               ramBe = txPtr[0] ? 2'b10 : 2'b01;
  end

  // R7: transmit pointer moves only on a transfer or a load
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.portWr && !stb.txLdLo && !stb.txLdHi) |=> $stable(txPtr));

  // R7: receive pointer moves only on a transfer or a load
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.portRd && !stb.rxLdLo && !stb.rxLdHi) |=> $stable(rxPtr));

  // R5: error flag stays set until the control register is written
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !stb.ctlWrLo) |=> errQ);

  // R1: a byte-mode RAM write touches exactly one lane
  a_r1_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && !wordModeQ) |-> ($countones(ramBe) == 1));

  // R10: no read strobe means zero read data next cycle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.portRd && !stb.regRd) |=> (hostRdata == 16'd0));
endmodule

// File: rtl/hostBufPort.sv
module hostBufPort
  import hbpPkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       hostAddr,
  input  logic [1:0]       hostBe,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [15:0]      hostWdata,
  output logic [15:0]      hostRdata,
  output logic [PTR_W-2:0] ramAddr,
  output logic             ramWe,
  output logic             ramRe,
  output logic [1:0]       ramBe,
  output logic [15:0]      ramWdata,
  input  logic [15:0]      ramRdata
);
  hbpStrobes_t stb;
  logic        wordMode;

  hbpCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostBe   (hostBe),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .wordMode (wordMode),
    .stb      (stb)
  );

  hbpDatapath #(.PTR_W(PTR_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .wordMode  (wordMode),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramRe     (ramRe),
    .ramBe     (ramBe),
    .ramWdata  (ramWdata),
    .ramRdata  (ramRdata)
  );
endmodule

// File: tb/hostBufPort_test.sv
module hostBufPort_test;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 11;
  localparam int WORDS = 1 << (PTR_W - 1);

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [1:0]  addr;
    logic [1:0]  be;
    logic [15:0] data;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'd1,2'b11,16'h0000,16'h0000,8'd7},  // R7 reset ctl
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h0000,8'd7},  // R7 reset tx
    '{1'b0,1'b1,2'd3,2'b11,16'h0000,16'h0000,8'd7},  // R7 reset rx
    '{1'b1,1'b0,2'd0,2'b01,16'h0011,16'h0000,8'd1},  // R1 byte 0
    '{1'b1,1'b0,2'd0,2'b01,16'h0022,16'h0000,8'd1},  // R1 byte 1
    '{1'b1,1'b0,2'd0,2'b11,16'hAB33,16'h0000,8'd1},  // R1 upper lane ignored
    '{1'b1,1'b0,2'd0,2'b10,16'h0044,16'h0000,8'd6},  // R6 no-op
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h0003,8'd6},  // R6 tx unmoved
    '{1'b0,1'b1,2'd0,2'b01,16'h0000,16'h0011,8'd2},  // R2
    '{1'b0,1'b1,2'd0,2'b01,16'h0000,16'h0022,8'd2},  // R2 odd lane
    '{1'b0,1'b1,2'd0,2'b01,16'h0000,16'h0033,8'd2},  // R2
    '{1'b0,1'b1,2'd3,2'b11,16'h0000,16'h0003,8'd2},  // R2 rx step 1
    '{1'b1,1'b0,2'd1,2'b01,16'h0001,16'h0000,8'd3},  // word mode on
    '{1'b1,1'b0,2'd2,2'b01,16'h0004,16'h0000,8'd7},  // R7 load tx
    '{1'b1,1'b0,2'd0,2'b11,16'hBEEF,16'h0000,8'd3},  // R3
    '{1'b1,1'b0,2'd0,2'b11,16'h1234,16'h0000,8'd3},  // R3
    '{1'b1,1'b0,2'd0,2'b01,16'h5555,16'h0000,8'd5},  // R5 partial
    '{1'b0,1'b1,2'd1,2'b11,16'h0000,16'h0003,8'd5},  // R5 err set
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h0008,8'd3},  // R3 tx step 2
    '{1'b1,1'b0,2'd3,2'b11,16'h0004,16'h0000,8'd7},  // R7 load rx
    '{1'b0,1'b1,2'd0,2'b11,16'h0000,16'hBEEF,8'd4},  // R4
    '{1'b0,1'b1,2'd0,2'b10,16'h0000,16'h0000,8'd5},  // R5 partial read
    '{1'b0,1'b1,2'd0,2'b11,16'h0000,16'h1234,8'd4},  // R4
    '{1'b0,1'b1,2'd3,2'b11,16'h0000,16'h0008,8'd4},  // R4 rx step 2
    '{1'b0,1'b1,2'd1,2'b11,16'h0000,16'h0003,8'd5},  // R5 still set
    '{1'b1,1'b0,2'd1,2'b01,16'h0003,16'h0000,8'd5},  // R5 clear
    '{1'b0,1'b1,2'd1,2'b11,16'h0000,16'h0001,8'd5},  // R5 cleared
    '{1'b1,1'b0,2'd2,2'b10,16'h0500,16'h0000,8'd8},  // R8 hi lane
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h0508,8'd8},  // R8
    '{1'b1,1'b0,2'd2,2'b01,16'h00FF,16'h0000,8'd8},  // R8 lo lane
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h05FF,8'd8},  // R8
    '{1'b1,1'b0,2'd1,2'b01,16'h0000,16'h0000,8'd9},  // byte mode
    '{1'b1,1'b0,2'd2,2'b11,16'h07FF,16'h0000,8'd9},  // top address
    '{1'b1,1'b0,2'd0,2'b01,16'h0077,16'h0000,8'd9},  // R9 write at top
    '{1'b0,1'b1,2'd2,2'b11,16'h0000,16'h0000,8'd9},  // R9 tx wrapped
    '{1'b1,1'b0,2'd3,2'b11,16'h07FF,16'h0000,8'd9},
    '{1'b0,1'b1,2'd0,2'b01,16'h0000,16'h0077,8'd9},  // R9 read at top
    '{1'b0,1'b1,2'd3,2'b11,16'h0000,16'h0000,8'd9},  // R9 rx wrapped
    '{1'b1,1'b0,2'd3,2'b11,16'h0005,16'h0000,8'd2}   // R2 setup byte 5
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       hostAddr = '0;
  logic [1:0]       hostBe = '0;
  logic             hostWr = 1'b0;
  logic             hostRd = 1'b0;
  logic [15:0]      hostWdata = '0;
  logic [15:0]      hostRdata;
  logic [PTR_W-2:0] ramAddr;
  logic             ramWe, ramRe;
  logic [1:0]       ramBe;
  logic [15:0]      ramWdata;
  logic [15:0]      ramRdata = '0;
  logic [15:0]      mem [WORDS];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostBufPort #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostBe(hostBe),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRe(ramRe), .ramBe(ramBe), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always_ff @(posedge clk) begin
    if (ramWe) begin
      if (ramBe[0]) mem[ramAddr][7:0]  <= ramWdata[7:0];
      if (ramBe[1]) mem[ramAddr][15:8] <= ramWdata[15:8];
    end
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [1:0] addr,
                        input logic [1:0] be, input logic [15:0] data,
                        output logic [15:0] got);
    @(negedge clk);
    hostWr = wr; hostRd = rd; hostAddr = addr; hostBe = be; hostWdata = data;
    @(negedge clk);
    got = hostRdata;
    hostWr = 1'b0; hostRd = 1'b0; hostBe = 2'b00;
  endtask

  initial begin
    logic [15:0] got;
    for (int i = 0; i < WORDS; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R10 reset idle", hostRdata, 16'h0000);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].be, VECS[i].data, got);
      if (VECS[i].rd)
        check($sformatf("R%0d vector %0d", VECS[i].req, i), got, VECS[i].exp);
    end
    // R2: byte read of high lane of a word-written location
    access(1'b0, 1'b1, 2'd0, 2'b01, 16'h0000, got);
    check("R2 byte of word", got, 16'h00BE);
    // R10: idle cycle after a read returns zero
    @(negedge clk);
    check("R10 idle zero", hostRdata, 16'h0000);
    // RAM contents written through the port
    check("R1 word0", mem[0], 16'h2211);
    check("R6 word1 hi untouched", mem[1], 16'h0033);
    check("R3 word2", mem[2], 16'hBEEF);
    check("R3 word3", mem[3], 16'h1234);
    check("R5 partial not stored", mem[4], 16'h0000);
    check("R9 top byte", mem[WORDS-1], 16'h7700);
    // R7: reset returns pointers and mode to zero
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(1'b0, 1'b1, 2'd3, 2'b11, 16'h0000, got);
    check("R7 rx after reset", got, 16'h0000);
    access(1'b0, 1'b1, 2'd1, 2'b11, 16'h0000, got);
    check("R7 ctl after reset", got, 16'h0000);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule